// File: doc/BRIEF.md
# Non-Overlapping 101 Pattern Counter

This block takes a data word and reports how many times the bit pattern 101 occurs in it when two occurrences may not share any bit. When two candidate occurrences would overlap, the one nearer the most significant bit wins. The word is resolved as a scan that starts at the top end. Each accepted occurrence uses up its three bits, and the scan goes on below them.

The logic is purely combinational and has two stages. The first stage builds a flag vector as wide as the input. Flag N is set when an accepted occurrence has input bit N as its middle bit. A flag cannot be decided from a fixed window of nearby bits, because whether a higher occurrence was accepted can depend on bits far away. The flags are therefore resolved in a chain that runs from the top of the word down to the bottom. The second stage counts the set flags and drives that count onto the output.

Top module: `trio_match_counter`

## Requirements
- R1: `count_o` equals the number of 101 occurrences in `data_i` under greedy matching from the MSB. The scan checks bits i, i-1, i-2. On a match it counts one and moves on to i-3. Otherwise it moves on to i-1. The count is a 4-bit unsigned value for the default 32-bit input.
- R2: Overlapping occurrences count once: a word whose only ones form 10101 gives 1, and a word whose only ones form 101101 gives 2.
- R3: The occurrence nearer the MSB takes priority. The seven bits 1010101, with all other bits zero, give 2.
- R4: The input 0x000000A9 (binary 10101001 in the low byte) gives 1.
- R5: The largest count is DATA_W/3, which is 10 for 32 bits. Ten back-to-back copies of 101 in bits 31..2 give exactly 10, and no input gives more.
- R6: An input of all zeros gives 0, and an input of all ones gives 0.
- R7: Long alternating runs resolve through the whole word. 0xAAAAAAAA gives 8 and 0x55555555 gives 8.
- R8: The internal flag vector is well formed:
  - a set flag N always has bits N+1, N, N-1 of the input equal to 1, 0, 1;
  - no two set flags are fewer than three positions apart;
  - the flags at bit 0 and at the top bit are never set.
- R9: The output is the population count of the flag vector. It follows any change of the input with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | DATA_W (32) | Word to be searched for the 101 pattern |
| count_o | output | CNT_W (4) | Number of non-overlapping occurrences, greedy from the MSB |

## Verification
The block has no registers, so every result is due in the same cycle as its stimulus. The bench changes `data_i` just after a rising edge of its own pacing clock and samples `count_o` at the following falling edge, half a period later. By then the combinational logic has settled, and no result depends on the order of events at an edge. Each sample is compared with a scanning reference model that runs on the same vector. The model covers the fixed corner words and a few hundred random words, including sparse ones that make long chains of decisions.

// File: rtl/trio_match_pkg.sv
package trio_match_pkg;

  // Highest number of disjoint 3-bit occurrences that fit in a word.
  function automatic int max_hits(input int width);
    return width / 3;
  endfunction

  // Bits needed to hold values 0..v.
  function automatic int bits_for(input int v);
    int n;
    n = 1;
    while ((1 << n) <= v) n++;
    return n;
  endfunction

endpackage

// File: rtl/trio_match_chain.sv
module trio_match_chain #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] flag_o
);

  // Local 101 candidates, one per middle position; the end bits have no pair of neighbours.
  logic [DATA_W-1:0] cand;

  genvar n;
  generate
    for (n = 0; n < DATA_W; n++) begin : g_cand
      if (n == 0 || n == DATA_W-1) begin : g_edge
        assign cand[n] = 1'b0;
      end else begin : g_mid
        assign cand[n] = data_i[n+1] & ~data_i[n] & data_i[n-1];
      end
    end
  endgenerate

  // Greedy resolution from the top: a candidate is taken only when neither of the
  // two positions above it was taken, since those would own its upper bits.
  logic [DATA_W+1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = DATA_W-1; k >= 0; k--) begin
      acc[k] = cand[k] & ~acc[k+1] & ~acc[k+2];
    end
  end

  assign flag_o = acc[DATA_W-1:0];

endmodule

// File: rtl/trio_ones_count.sv
module trio_ones_count #(
  parameter int IN_W  = 32,
  parameter int GRP_W = 4,
  parameter int OUT_W = 4
) (
  input  logic [IN_W-1:0]  vec_i,
  output logic [OUT_W-1:0] ones_o
);

  localparam int NGRP  = (IN_W + GRP_W - 1) / GRP_W;
  localparam int PAD_W = NGRP * GRP_W;
  localparam int GC_W  = trio_match_pkg::bits_for(GRP_W);
  localparam int SUM_W = trio_match_pkg::bits_for(IN_W);

  logic [PAD_W-1:0] padded;
  logic [GC_W-1:0]  grp_cnt [NGRP];
  logic [SUM_W-1:0] total;

  generate
    if (PAD_W > IN_W) begin : g_pad
      assign padded = {{(PAD_W-IN_W){1'b0}}, vec_i};
    end else begin : g_nopad
      assign padded = vec_i;
    end
  endgenerate

  // First level: small counts over fixed slices of the vector.
  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : g_grp
      always_comb begin
        grp_cnt[g] = '0;
        for (int b = 0; b < GRP_W; b++) begin
          grp_cnt[g] = grp_cnt[g] + GC_W'(padded[g*GRP_W+b]);
        end
      end
    end
  endgenerate

  // Second level: add the slice counts.
  always_comb begin
    total = '0;
    for (int j = 0; j < NGRP; j++) begin
      total = total + SUM_W'(grp_cnt[j]);
    end
  end

  // The count cannot exceed DATA_W/3, so the narrow output holds every reachable value.
  assign ones_o = total[OUT_W-1:0];

endmodule

// File: rtl/trio_match_counter.sv
module trio_match_counter #(
  parameter int DATA_W = 32,
  parameter int GRP_W  = 4,
  parameter int CNT_W  = trio_match_pkg::bits_for(trio_match_pkg::max_hits(DATA_W))
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CNT_W-1:0]  count_o
);

  logic [DATA_W-1:0] match_flags;

  trio_match_chain #(
    .DATA_W (DATA_W)
  ) u_chain (
    .data_i (data_i),
    .flag_o (match_flags)
  );

  trio_ones_count #(
    .IN_W  (DATA_W),
    .GRP_W (GRP_W),
    .OUT_W (CNT_W)
  ) u_count (
    .vec_i  (match_flags),
    .ones_o (count_o)
  );

endmodule

// File: rtl/trio_match_checker.sv
module trio_match_checker #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W-1:0] flags,
  input logic [CNT_W-1:0]  count_o
);

  localparam int MAXC = trio_match_pkg::max_hits(DATA_W);

  always_comb begin
    if (!$isunknown(data_i) && !$isunknown(flags)) begin
      // R8
      spacing_chk: assert (((flags & (flags >> 1)) == '0) && ((flags & (flags >> 2)) == '0))
        else $error("flags closer than three positions: %h", flags);
      // R8
      pattern_chk: assert ((flags & ~((data_i >> 1) & ~data_i & (data_i << 1))) == '0)
        else $error("flag set without a 101 around it: flags %h data %h", flags, data_i);
      // R8
      ends_chk: assert (!flags[0] && !flags[DATA_W-1])
        else $error("end flag set: %h", flags);
      // R9
      popcount_chk: assert (32'(count_o) == 32'($countones(flags)))
        else $error("count %0d does not match flags %h", count_o, flags);
      // R5
      max_count_chk: assert (32'(count_o) <= MAXC)
        else $error("count %0d above limit", count_o);
      // R6
      zero_input_chk: assert ((data_i != '0) || (count_o == '0))
        else $error("zero word gave count %0d", count_o);
    end
  end

endmodule

bind trio_match_counter trio_match_checker #(
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_checker (
  .data_i  (data_i),
  .flags   (match_flags),
  .count_o (count_o)
);

// File: tb/sim_trio_match_counter.sv
`timescale 1ns/1ps
module sim_trio_match_counter;

  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;

  logic clk;
  logic rst_n;
  logic [DATA_W-1:0] data_i;
  logic [CNT_W-1:0]  count_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  trio_match_counter u0 (
    .data_i  (data_i),
    .count_o (count_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference: scan from the top, skip three after a hit, one otherwise.
  function automatic int ref_count(input logic [DATA_W-1:0] d);
    int i;
    int c;
    i = DATA_W - 1;
    c = 0;
    while (i >= 2) begin
      if (d[i] && !d[i-1] && d[i-2]) begin
        c++;
        i -= 3;
      end else begin
        i -= 1;
      end
    end
    return c;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: data %h got %0d expected %0d", tag, data_i, got, exp);
    end
  endtask

  // Drive after a rising edge, sample at the falling edge.
  task automatic apply(input logic [DATA_W-1:0] d, input string tag, input int fixed_exp);
    @(posedge clk);
    #1;
    data_i = d;
    @(negedge clk);
    check({tag, " model"}, int'(count_o), ref_count(d));
    if (fixed_exp >= 0) check(tag, int'(count_o), fixed_exp);
  endtask

  initial begin
    logic [DATA_W-1:0] maxw;
    logic [DATA_W-1:0] r;
    rst_n  = 1'b0;
    data_i = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset-state zero input", int'(count_o), 0);

    apply(32'h0000_0000, "R6 all zeros", 0);
    apply(32'hFFFF_FFFF, "R6 all ones", 0);
    apply(32'h0000_0015, "R2 10101", 1);
    apply(32'h0000_002D, "R2 101101", 2);
    apply(32'h0000_0055, "R3 1010101", 2);
    apply(32'h5500_0000, "R3 1010101 high", 2);
    apply(32'h0000_00A9, "R4 10101001", 1);
    apply(32'hAAAA_AAAA, "R7 alternating A", 8);
    apply(32'h5555_5555, "R7 alternating 5", 8);
    apply(32'hA000_0005, "R1 both ends", 2);

    maxw = '0;
    for (int k = 0; k < 10; k++) maxw = {maxw[DATA_W-4:0], 3'b101};
    maxw = {maxw[DATA_W-3:0], 2'b00};
    apply(maxw, "R5 ten back to back", 10);

    for (int k = 0; k < 300; k++) begin
      r = $urandom();
      if (k % 3 == 1) r = r & $urandom();
      if (k % 3 == 2) r = r | 32'hAAAA_AAAA;
      apply(r, "R1 R9 random", -1);
      if (int'(count_o) > 10) check("R5 bound", int'(count_o), 10);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule